// File: doc/BRIEF.md
# Scattered-Map Interrupt Controller

This block collects up to 64 level-sensitive interrupt request lines and gives software one register window to control them. Each source number goes to a fixed, irregular place in one of two 32-bit words: a "high" word and a "low" word. A source number does not pick the bit with the same index. The mask pair and the pending pair both use this same layout.

A request sets its pending flag, and that flag stays set until software clears it with a write-one-to-clear. A source is eligible when its pending flag is set and its mask bit is 1. The block reports the lowest-numbered eligible source in the top six bits of a read-only vector register. It also drives one interrupt line while any eligible source exists.

A configuration word and two priority-grouping words are stored and read back. They do not change how the vector is chosen.

Top module: `irq_scatter_ctrl`

## Requirements
- R1: After reset, both mask words, both pending words, the vector register and the configuration word read 0, `irq_out` is 0, and both priority words read 0x05309770.
- R2: Both mask words (address 0 = high word, address 1 = low word) read back the last value written to them.
- R3: Source s has a fixed word and bit position:
  - Source 0 is in the low word at bit 0.
  - Sources 1–15 are in the low word at bit 16−s.
  - Sources 16–18 are in the high word at bit 18−s.
  - Sources 19–30 are in the high word at bit 33−s.
  - Source 31 is in the high word at bit 15.
  - Sources 32–47 are in the low word at bit 63−s.
  - Sources 48–63 are in the high word at bit s−32.
  - The pending words are read at address 2 (high) and address 3 (low).
- R4: A request that is high at a clock edge sets its pending flag at that edge. The flag stays set after the request drops.
- R5: Writing a 1 to a pending-word bit clears that flag. A 0 bit in the written value leaves its flag unchanged.
- R6: If a flag is cleared in a cycle where its request is still high, the set wins and the flag reads 1.
- R7: `irq_out` is 1 exactly when some pending flag has its mask bit at 1. It follows any change of pending or mask state by one clock. A mask bit of 0 blocks its source.
- R8: The vector register (address 4) holds the lowest-numbered eligible source, 1 to 63, in bits 31:26. Bits 25:0 read 0. The field reads 0 when no source is eligible.
- R9: Reading the vector register changes nothing. A write to it is ignored.
- R10: The configuration word (address 5) and the two priority words (addresses 6 and 7) read back the last value written.
- R11: Source 0 is reserved: its request line never sets a pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 64 | Level request lines, indexed by source number |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational from register state |
| irq_out | output | 1 | Asserted while any unmasked source is pending |

## Verification
A fault in the scatter table shows up at once. After a single request, the pending flag appears in the wrong word or bit on the next read, and the vector names another source two clocks after the request. A pending flag that is lost or stuck shows the same way: after an acknowledge, `irq_out` or the vector stays wrong from the second edge on. A wrong priority order shows only when two sources are eligible together. The bench therefore sweeps every source alone, then runs pairs spread across both words, with and without masking of the lower-numbered one.

// File: rtl/irq_scatter_pkg.sv
package irq_scatter_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned NSRC    = 64;
    localparam int unsigned VEC_W   = $clog2(NSRC);
    localparam int unsigned ADDR_W  = 3;
    localparam logic [WORD_W-1:0] PRIO_RESET = 32'h0530_9770;

    localparam logic [ADDR_W-1:0] A_MASK_HI = 3'd0;
    localparam logic [ADDR_W-1:0] A_MASK_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_PEND_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_PEND_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_VECTOR  = 3'd4;
    localparam logic [ADDR_W-1:0] A_CONFIG  = 3'd5;
    localparam logic [ADDR_W-1:0] A_PRIO_A  = 3'd6;
    localparam logic [ADDR_W-1:0] A_PRIO_B  = 3'd7;

    typedef struct packed {
        logic [WORD_W-1:0] mask_hi;
        logic [WORD_W-1:0] mask_lo;
        logic [WORD_W-1:0] pend_hi;
        logic [WORD_W-1:0] pend_lo;
        logic [WORD_W-1:0] config_w;
        logic [WORD_W-1:0] prio_a;
        logic [WORD_W-1:0] prio_b;
        logic [VEC_W-1:0]  vec;
        logic              irq;
    } ctl_state_t;

    // True when source s lives in the low word.
    function automatic bit src_in_low(input int s);
        return (s < 16) || (s >= 32 && s < 48);
    endfunction

    // Bit position of source s inside its word.
    function automatic int src_bit(input int s);
        if (s == 0)       return 0;
        else if (s < 16)  return 16 - s;
        else if (s < 19)  return 18 - s;
        else if (s < 31)  return 33 - s;
        else if (s == 31) return 15;
        else if (s < 48)  return 63 - s;
        else              return s - 32;
    endfunction

endpackage

// File: rtl/irq_scatter_map.sv
// Routes per-source lines into the high/low register word layout.
module irq_scatter_map
    import irq_scatter_pkg::*;
#(
    parameter int unsigned N_SRC = NSRC,
    parameter int unsigned W     = WORD_W
) (
    input  logic [N_SRC-1:0] src_i,
    output logic [W-1:0]     hi_o,
    output logic [W-1:0]     lo_o
);
    for (genvar s = 0; s < N_SRC; s++) begin : g_route
        if (src_in_low(s)) begin : g_lo
            assign lo_o[src_bit(s)] = src_i[s];
        end else begin : g_hi
            assign hi_o[src_bit(s)] = src_i[s];
        end
    end
endmodule

// File: rtl/irq_gather_map.sv
// Collects high/low register words back into source-number order.
module irq_gather_map
    import irq_scatter_pkg::*;
#(
    parameter int unsigned N_SRC = NSRC,
    parameter int unsigned W     = WORD_W
) (
    input  logic [W-1:0]     hi_i,
    input  logic [W-1:0]     lo_i,
    output logic [N_SRC-1:0] src_o
);
    for (genvar s = 0; s < N_SRC; s++) begin : g_route
        if (src_in_low(s)) begin : g_lo
            assign src_o[s] = lo_i[src_bit(s)];
        end else begin : g_hi
            assign src_o[s] = hi_i[src_bit(s)];
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority pick: lowest-numbered eligible source, source 0 excluded.
module irq_prio_pick
    import irq_scatter_pkg::*;
#(
    parameter int unsigned N_SRC = NSRC,
    localparam int unsigned IW   = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] elig_i,
    output logic             any_o,
    output logic [IW-1:0]    idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int s = N_SRC - 1; s >= 1; s--) begin
            if (elig_i[s]) begin
                any_o = 1'b1;
                idx_o = IW'(s);
            end
        end
    end

    // R8: the chosen index is eligible and never the reserved zero.
    p_pick_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> (elig_i[idx_o] && idx_o != '0));
endmodule

// File: rtl/irq_scatter_ctrl.sv
module irq_scatter_ctrl
    import irq_scatter_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq_out
);
    localparam int unsigned VEC_LSB = WORD_W - VEC_W;

    ctl_state_t st_q, st_d;

    logic [NSRC-1:0]   req_eff;
    logic [WORD_W-1:0] req_hi, req_lo;
    logic [NSRC-1:0]   elig_src;
    logic              pick_any;
    logic [VEC_W-1:0]  pick_idx;

    // R11: source 0 is reserved and never requests.
    assign req_eff = {irq_req[NSRC-1:1], 1'b0};

    irq_scatter_map #(.N_SRC(NSRC), .W(WORD_W)) u_scatter (
        .src_i (req_eff),
        .hi_o  (req_hi),
        .lo_o  (req_lo)
    );

    irq_gather_map #(.N_SRC(NSRC), .W(WORD_W)) u_gather (
        .hi_i  (st_q.pend_hi & st_q.mask_hi),
        .lo_i  (st_q.pend_lo & st_q.mask_lo),
        .src_o (elig_src)
    );

    irq_prio_pick #(.N_SRC(NSRC)) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .elig_i (elig_src),
        .any_o  (pick_any),
        .idx_o  (pick_idx)
    );

    always_comb begin
        logic [WORD_W-1:0] clr_hi, clr_lo;
        st_d   = st_q;
        clr_hi = (bus_we && bus_addr == A_PEND_HI) ? bus_wdata : '0;
        clr_lo = (bus_we && bus_addr == A_PEND_LO) ? bus_wdata : '0;
        // Set wins over clear so a still-active level re-pends (R6).
        st_d.pend_hi = (st_q.pend_hi & ~clr_hi) | req_hi;
        st_d.pend_lo = (st_q.pend_lo & ~clr_lo) | req_lo;
        if (bus_we) begin
            unique case (bus_addr)
                A_MASK_HI: st_d.mask_hi  = bus_wdata;
                A_MASK_LO: st_d.mask_lo  = bus_wdata;
                A_CONFIG:  st_d.config_w = bus_wdata;
                A_PRIO_A:  st_d.prio_a   = bus_wdata;
                A_PRIO_B:  st_d.prio_b   = bus_wdata;
                default: ;
            endcase
        end
        st_d.irq = |((st_q.pend_hi & st_q.mask_hi) | (st_q.pend_lo & st_q.mask_lo));
        st_d.vec = pick_any ? pick_idx : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.prio_a   <= PRIO_RESET;
            st_q.prio_b   <= PRIO_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_MASK_HI: bus_rdata = st_q.mask_hi;
            A_MASK_LO: bus_rdata = st_q.mask_lo;
            A_PEND_HI: bus_rdata = st_q.pend_hi;
            A_PEND_LO: bus_rdata = st_q.pend_lo;
            A_VECTOR:  bus_rdata = {st_q.vec, {VEC_LSB{1'b0}}};
            A_CONFIG:  bus_rdata = st_q.config_w;
            A_PRIO_A:  bus_rdata = st_q.prio_a;
            default:   bus_rdata = st_q.prio_b;
        endcase
    end

    assign irq_out = st_q.irq;

    p_mask_hi_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_MASK_HI) |=> st_q.mask_hi == $past(bus_wdata));

    p_mask_lo_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_MASK_LO) |=> st_q.mask_lo == $past(bus_wdata));

    p_pend_hi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == A_PEND_HI)
        |=> (st_q.pend_hi & $past(st_q.pend_hi)) == $past(st_q.pend_hi));

    p_pend_lo_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == A_PEND_LO)
        |=> (st_q.pend_lo & $past(st_q.pend_lo)) == $past(st_q.pend_lo));

    p_req_pends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_req[NSRC-1:1]) |=> (|{st_q.pend_hi, st_q.pend_lo}));

    p_irq_vec_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (st_q.vec != '0));
endmodule

// File: tb/irq_scatter_ctrl_bench.sv
module irq_scatter_ctrl_bench;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_req = '0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_NS/2) clk = ~clk;

    irq_scatter_ctrl u_irq_scatter_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // Expected placement: returns 1 when in low word; pos gets the bit.
    function automatic bit exp_low(input int s, output int pos);
        if (s >= 48)      begin pos = s - 32; return 0; end
        else if (s >= 32) begin pos = 63 - s; return 1; end
        else if (s == 31) begin pos = 15;     return 0; end
        else if (s >= 19) begin pos = 33 - s; return 0; end
        else if (s >= 16) begin pos = 18 - s; return 0; end
        else if (s >= 1)  begin pos = 16 - s; return 1; end
        else              begin pos = 0;      return 1; end
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d, d2;
        int pos, pa, pb;
        bit la, lb;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d); chk("R1 reset reg", d, 32'h0);
        end
        rd(3'd6, d); chk("R1 prio_a default", d, 32'h0530_9770);
        rd(3'd7, d); chk("R1 prio_b default", d, 32'h0530_9770);
        chk("R1 irq_out", {31'b0, irq_out}, 32'h0);

        // R2 mask readback
        wr(3'd0, 32'hA5C3_0F96); rd(3'd0, d); chk("R2 mask hi", d, 32'hA5C3_0F96);
        wr(3'd1, 32'h5A3C_F069); rd(3'd1, d); chk("R2 mask lo", d, 32'h5A3C_F069);
        wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);

        // R10 config and priority words
        wr(3'd5, 32'h1234_5678); rd(3'd5, d); chk("R10 config", d, 32'h1234_5678);
        wr(3'd6, 32'h0BAD_F00D); rd(3'd6, d); chk("R10 prio_a", d, 32'h0BAD_F00D);
        wr(3'd7, 32'hCAFE_0001); rd(3'd7, d); chk("R10 prio_b", d, 32'hCAFE_0001);

        // R11 reserved source 0
        @(negedge clk); irq_req = 64'h1;
        @(negedge clk); @(negedge clk); irq_req = '0;
        @(negedge clk);
        rd(3'd3, d); chk("R11 src0 pend lo", d, 32'h0);
        chk("R11 src0 irq", {31'b0, irq_out}, 32'h0);

        // Sweep every source alone: R3 R4 R5 R7 R8
        for (int s = 1; s < 64; s++) begin
            la = exp_low(s, pos);
            irq_req = 64'h1 << s;
            @(negedge clk);
            irq_req = '0;
            @(negedge clk);
            rd(3'd2, d);  chk($sformatf("R3 R4 src%0d pend hi", s), d, la ? 32'h0 : (32'h1 << pos));
            rd(3'd3, d2); chk($sformatf("R3 R4 src%0d pend lo", s), d2, la ? (32'h1 << pos) : 32'h0);
            rd(3'd4, d);  chk($sformatf("R8 src%0d vector", s), d, {6'(s), 26'b0});
            chk($sformatf("R7 src%0d irq", s), {31'b0, irq_out}, 32'h1);
            wr(la ? 3'd3 : 3'd2, ~(32'h1 << pos) & 32'h0);
            wr(la ? 3'd3 : 3'd2, 32'h0);
            rd(la ? 3'd3 : 3'd2, d); chk($sformatf("R5 src%0d zero write", s), d, 32'h1 << pos);
            wr(la ? 3'd3 : 3'd2, 32'h1 << pos);
            rd(la ? 3'd3 : 3'd2, d); chk($sformatf("R5 src%0d cleared", s), d, 32'h0);
            chk($sformatf("R7 src%0d irq lag", s), {31'b0, irq_out}, 32'h1);
            @(negedge clk);
            chk($sformatf("R7 src%0d irq off", s), {31'b0, irq_out}, 32'h0);
            rd(3'd4, d); chk($sformatf("R8 src%0d vector empty", s), d, 32'h0);
        end

        // Pairs: R8 lowest wins, masking lower hands over to higher (R7)
        for (int a = 1; a < 32; a += 5) begin
            int b;
            b = 63 - a;
            la = exp_low(a, pa);
            lb = exp_low(b, pb);
            irq_req = (64'h1 << a) | (64'h1 << b);
            @(negedge clk);
            irq_req = '0;
            @(negedge clk);
            rd(3'd4, d); chk($sformatf("R8 pair %0d/%0d", a, b), d, {6'(a), 26'b0});
            wr(la ? 3'd1 : 3'd0, ~(32'h1 << pa));
            @(negedge clk);
            rd(3'd4, d); chk($sformatf("R8 R7 masked %0d gives %0d", a, b), d, {6'(b), 26'b0});
            wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
            wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);
            @(negedge clk);
        end

        // R7 mask 0 blocks
        wr(3'd0, 32'h0); wr(3'd1, 32'h0);
        irq_req = 64'h1 << 5;
        @(negedge clk); irq_req = '0;
        @(negedge clk); @(negedge clk);
        rd(3'd3, d); chk("R7 blocked still pending", d, 32'h1 << 11);
        chk("R7 blocked irq", {31'b0, irq_out}, 32'h0);
        rd(3'd4, d); chk("R8 blocked vector", d, 32'h0);
        wr(3'd1, 32'h1 << 11);
        @(negedge clk);
        chk("R7 unmask irq", {31'b0, irq_out}, 32'h1);

        // R9 vector read has no effect, write ignored
        rd(3'd4, d); rd(3'd4, d2); chk("R9 reread", d2, d);
        wr(3'd4, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(3'd4, d2); chk("R9 write ignored", d2, {6'd5, 26'b0});
        rd(3'd3, d); chk("R9 pending intact", d, 32'h1 << 11);

        // R6 ack while still requesting
        irq_req = 64'h1 << 5;
        @(negedge clk);
        wr(3'd3, 32'h1 << 11);
        rd(3'd3, d); chk("R6 re-pend", d, 32'h1 << 11);
        irq_req = '0;
        wr(3'd3, 32'h1 << 11);
        rd(3'd3, d); chk("R6 clear after drop", d, 32'h0);

        summary();
        $finish;
    end
endmodule